// File: doc/BRIEF.md
# Flash Program Command Controller

This block is the device-side control logic of a word-wide flash array (64K words of 16 bits on the bus) that takes its commands as writes on an asynchronous memory bus. The bus has active-low chip-enable, output-enable and write-enable strobes, a 16-bit address and a 16-bit data path, which is split into input, output and output-enable. The strobes are resynchronised into a fast system clock. Write-enable edges are detected there, and they drive a small command state machine.

Programming a word takes two write cycles. The first write carries the program-setup code in the low data byte. The second write carries the target word: its address is captured when write enable is asserted and its data when write enable is released. An internal stop timer then bounds the program pulse. While the timer runs the block reports busy, and the stored word becomes the AND of its old value and the new data. A later program-verify command reads back the word at the address latched by the program write, whatever is on the address bus. Any other command value returns the block to plain array reads. The model array is `ARR_AW` address bits deep and indexed by the low address bits.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset, busy is 0, dq_oe is 0, the block is in read mode and every array word reads 16'hFFFF.
- R2: dq_oe is 1 only when, after the strobe synchroniser, ce_n and oe_n are low and we_n is high. Outside those conditions it stays 0.
- R3: In read mode, dq_o returns the array word at the low ARR_AW bits of addr_i.
- R4: A write whose low data byte is 8'h40 arms a program. The next write cycle is the program write: the address is taken while write enable is asserted and the data at its release. At the end of the program pulse the word becomes old AND data, and other words are left unchanged.
- R5: busy rises after the program write's release and stays high for exactly PGM_CYC clock cycles. Every write cycle that completes while busy is high is ignored.
- R6: A write whose low data byte is 8'hC0 enters verify mode. In verify mode dq_o returns the word at the address latched by the last program write, independent of addr_i, and that latched address does not change until the next command write.
- R7: Any low data byte other than 8'h40 or 8'hC0, written outside a program sequence, returns the block to read mode.
- R8: After each completed write cycle, dq_oe stays 0 for RECOV_CYC clock cycles, even when the read strobes are active.
- R9: Bits 15:8 of a command write do not affect how it is decoded.
- R10: Write-enable pulses while ce_n is high are ignored. A pending program setup survives such a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the strobes |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr_i | input | ADDR_W | Word address from the bus |
| dq_i | input | DATA_W | Data and commands written by the host |
| dq_o | output | DATA_W | Read data (array word or verify word) |
| dq_oe | output | 1 | Drive enable for the data pins |
| busy | output | 1 | High while the program stop timer runs |

## Verification
The stop-timer expiry can coincide with a read of the word being programmed. The read port registers the old word in the same clock edge where the AND result is written. The bench holds a read on the target address throughout the pulse and samples dq_o at the first half-cycle after busy falls, where it expects the erased value. One cycle later it expects the programmed value. A write arriving during busy is placed so that it lands halfway through the pulse, and it is judged by a later write that could only program if the ignored write had been taken as a setup command.

// File: rtl/fcc_pkg.sv
`timescale 1ns/1ps
package fcc_pkg;

    localparam logic [7:0] CMD_PROG_SETUP  = 8'h40;
    localparam logic [7:0] CMD_PROG_VERIFY = 8'hC0;

    // strobe positions inside the synchroniser vector
    localparam int SI_CE    = 0;
    localparam int SI_OE    = 1;
    localparam int SI_WE    = 2;
    localparam int N_STROBE = 3;

    typedef enum logic [1:0] {
        ST_READ   = 2'd0,
        ST_SETUP  = 2'd1,
        ST_PROG   = 2'd2,
        ST_VERIFY = 2'd3
    } mode_e;

    typedef struct packed {
        logic open;   // write enable asserted while chip selected
        logic close;  // write enable released while chip selected
    } wr_evt_t;

    function automatic mode_e decode_cmd(input logic [7:0] code);
        case (code)
            CMD_PROG_SETUP:  return ST_SETUP;
            CMD_PROG_VERIFY: return ST_VERIFY;
            default:         return ST_READ;
        endcase
    endfunction

endpackage

// File: rtl/fcc_strobe_sync.sv
`timescale 1ns/1ps
module fcc_strobe_sync #(
    parameter int N      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] raw_n,
    output logic [N-1:0] lvl,
    output logic [N-1:0] asrt,
    output logic [N-1:0] rels
);

    generate
        for (genvar i = 0; i < N; i++) begin : g_ch
            logic [STAGES-1:0] sh;
            logic              prev;

            always_ff @(posedge clk) begin
                if (rst) begin
                    sh   <= '0;
                    prev <= 1'b0;
                end else begin
                    sh   <= {sh[STAGES-2:0], ~raw_n[i]};
                    prev <= sh[STAGES-1];
                end
            end

            assign lvl[i]  = sh[STAGES-1];
            assign asrt[i] = sh[STAGES-1] & ~prev;
            assign rels[i] = ~sh[STAGES-1] & prev;
        end
    endgenerate

endmodule

// File: rtl/fcc_prog_timer.sv
`timescale 1ns/1ps
module fcc_prog_timer #(
    parameter int CYCLES = 2000
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic run,
    output logic done
);

    localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= '0;
        end else if (run && cnt != LAST) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign done = run && (cnt == LAST);

endmodule

// File: rtl/fcc_word_array.sv
`timescale 1ns/1ps
module fcc_word_array #(
    parameter int AW = 10,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '1;
            end
            rd_data <= '1;
        end else begin
            if (wr_en) begin
                mem[wr_addr] <= mem[wr_addr] & wr_data;
            end
            rd_data <= mem[rd_addr];
        end
    end

endmodule

// File: rtl/fcc_seq.sv
`timescale 1ns/1ps
module fcc_seq
    import fcc_pkg::*;
#(
    parameter int AW        = 16,
    parameter int DW        = 16,
    parameter int RECOV_CYC = 1200
) (
    input  logic          clk,
    input  logic          rst,
    input  wr_evt_t       wr,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] dq_i,
    input  logic          tmr_done,
    output mode_e         mode,
    output logic [AW-1:0] lat_addr,
    output logic [DW-1:0] lat_data,
    output logic          tmr_start,
    output logic          commit,
    output logic          rd_block
);

    localparam int RW = (RECOV_CYC > 0) ? $clog2(RECOV_CYC + 1) : 1;
    localparam logic [RW-1:0] RECOV_LOAD = RW'(RECOV_CYC);

    logic [RW-1:0] recov;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode     <= ST_READ;
            lat_addr <= '0;
            lat_data <= '1;
            recov    <= '0;
        end else begin
            if (wr.close) begin
                recov <= RECOV_LOAD;
            end else if (recov != '0) begin
                recov <= recov - 1'b1;
            end

            case (mode)
                ST_PROG: begin
                    if (tmr_done) begin
                        mode <= ST_READ;
                    end
                end
                ST_SETUP: begin
                    if (wr.open) begin
                        lat_addr <= addr_i;
                    end
                    if (wr.close) begin
                        lat_data <= dq_i;
                        mode     <= ST_PROG;
                    end
                end
                default: begin
                    if (wr.close) begin
                        mode <= decode_cmd(dq_i[7:0]);
                    end
                end
            endcase
        end
    end

    assign tmr_start = (mode == ST_SETUP) && wr.close;
    assign commit    = (mode == ST_PROG) && tmr_done;
    assign rd_block  = (recov != '0);

endmodule

// File: rtl/flash_cmd_ctrl.sv
`timescale 1ns/1ps
module flash_cmd_ctrl
    import fcc_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 16,
    parameter int ARR_AW      = 10,
    parameter int PGM_CYC     = 2000,
    parameter int RECOV_CYC   = 1200,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] dq_i,
    output logic [DATA_W-1:0] dq_o,
    output logic              dq_oe,
    output logic              busy
);

    logic [N_STROBE-1:0] raw_n;
    logic [N_STROBE-1:0] lvl;
    logic [N_STROBE-1:0] asrt;
    logic [N_STROBE-1:0] rels;
    wr_evt_t             wr;
    mode_e               mode;
    logic [ADDR_W-1:0]   lat_addr;
    logic [DATA_W-1:0]   lat_data;
    logic                tmr_start;
    logic                tmr_done;
    logic                commit;
    logic                rd_block;
    logic [ARR_AW-1:0]   rd_addr;

    assign raw_n[SI_CE] = ce_n;
    assign raw_n[SI_OE] = oe_n;
    assign raw_n[SI_WE] = we_n;

    fcc_strobe_sync #(
        .N      (N_STROBE),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst   (rst),
        .raw_n (raw_n),
        .lvl   (lvl),
        .asrt  (asrt),
        .rels  (rels)
    );

    assign wr.open  = asrt[SI_WE] & lvl[SI_CE];
    assign wr.close = rels[SI_WE] & lvl[SI_CE];

    fcc_seq #(
        .AW        (ADDR_W),
        .DW        (DATA_W),
        .RECOV_CYC (RECOV_CYC)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .wr        (wr),
        .addr_i    (addr_i),
        .dq_i      (dq_i),
        .tmr_done  (tmr_done),
        .mode      (mode),
        .lat_addr  (lat_addr),
        .lat_data  (lat_data),
        .tmr_start (tmr_start),
        .commit    (commit),
        .rd_block  (rd_block)
    );

    fcc_prog_timer #(
        .CYCLES (PGM_CYC)
    ) u_tmr (
        .clk   (clk),
        .rst   (rst),
        .start (tmr_start),
        .run   (mode == ST_PROG),
        .done  (tmr_done)
    );

    assign rd_addr = (mode == ST_VERIFY) ? lat_addr[ARR_AW-1:0] : addr_i[ARR_AW-1:0];

    fcc_word_array #(
        .AW (ARR_AW),
        .DW (DATA_W)
    ) u_arr (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (commit),
        .wr_addr (lat_addr[ARR_AW-1:0]),
        .wr_data (lat_data),
        .rd_addr (rd_addr),
        .rd_data (dq_o)
    );

    assign busy  = (mode == ST_PROG);
    assign dq_oe = lvl[SI_CE] & lvl[SI_OE] & ~lvl[SI_WE] & ~rd_block;

    logic unused_edges;
    assign unused_edges = ^{asrt[SI_CE], asrt[SI_OE], rels[SI_CE], rels[SI_OE]};

    generate
        if (ADDR_W > ARR_AW) begin : g_hi
            logic unused_hi;
            assign unused_hi = ^lat_addr[ADDR_W-1:ARR_AW];
        end
    endgenerate

endmodule

// File: rtl/fcc_checker.sv
`timescale 1ns/1ps
module fcc_checker
    import fcc_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int PGM_CYC   = 2000,
    parameter int RECOV_CYC = 1200
) (
    input logic                clk,
    input logic                rst,
    input logic                ce_n,
    input logic                oe_n,
    input logic                we_n,
    input logic                dq_oe,
    input logic                busy,
    input mode_e               mode,
    input logic [ADDR_W-1:0]   lat_addr,
    input logic [N_STROBE-1:0] lvl
);

    logic [31:0] busy_run;
    logic [31:0] since_rel;
    logic        we_prev;
    logic        rel_seen;

    assign rel_seen = we_prev & ~lvl[SI_WE] & lvl[SI_CE];

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_run  <= '0;
            since_rel <= 32'(RECOV_CYC);
            we_prev   <= 1'b0;
        end else begin
            busy_run <= busy ? busy_run + 1 : '0;
            we_prev  <= lvl[SI_WE];
            if (rel_seen) begin
                since_rel <= '0;
            end else if (since_rel < 32'(RECOV_CYC)) begin
                since_rel <= since_rel + 1;
            end
        end
    end

    AST_OE_NEEDS_STROBES: assert property (@(posedge clk) disable iff (rst)
        dq_oe |-> (!$past(ce_n, 2) && !$past(oe_n, 2) && $past(we_n, 2))); // R2

    AST_RECOVERY_GAP: assert property (@(posedge clk) disable iff (rst)
        dq_oe |-> (since_rel >= 32'(RECOV_CYC))); // R8

    AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (busy_run == 32'(PGM_CYC))); // R5

    AST_BUSY_AFTER_SETUP: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> ($past(mode) == ST_SETUP)); // R4

    AST_VERIFY_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
        (mode == ST_VERIFY && $past(mode) == ST_VERIFY) |-> $stable(lat_addr)); // R6

endmodule

bind flash_cmd_ctrl fcc_checker #(
    .ADDR_W    (ADDR_W),
    .PGM_CYC   (PGM_CYC),
    .RECOV_CYC (RECOV_CYC)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .ce_n     (ce_n),
    .oe_n     (oe_n),
    .we_n     (we_n),
    .dq_oe    (dq_oe),
    .busy     (busy),
    .mode     (mode),
    .lat_addr (lat_addr),
    .lvl      (lvl)
);

// File: tb/tb_flash_cmd_ctrl.sv
`timescale 1ns/1ps
module tb_flash_cmd_ctrl;

    localparam int P   = 40;
    localparam int R   = 20;
    localparam int AAW = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ce_n = 1'b1;
    logic        oe_n = 1'b1;
    logic        we_n = 1'b1;
    logic [15:0] addr = '0;
    logic [15:0] dq_i = '0;
    logic [15:0] dq_o;
    logic        dq_oe;
    logic        busy;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    flash_cmd_ctrl #(
        .ADDR_W    (16),
        .DATA_W    (16),
        .ARR_AW    (AAW),
        .PGM_CYC   (P),
        .RECOV_CYC (R)
    ) dut (
        .clk    (clk),
        .rst    (rst),
        .ce_n   (ce_n),
        .oe_n   (oe_n),
        .we_n   (we_n),
        .addr_i (addr),
        .dq_i   (dq_i),
        .dq_o   (dq_o),
        .dq_oe  (dq_oe),
        .busy   (busy)
    );

    task automatic chk(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [15:0] d, input logic sel = 1'b1);
        @(negedge clk);
        ce_n = ~sel;
        addr = a;
        dq_i = d;
        repeat (3) @(negedge clk);
        we_n = 1'b0;
        repeat (6) @(negedge clk);
        we_n = 1'b1;
        repeat (6) @(negedge clk);
        ce_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic rd(input logic [15:0] a, output logic [15:0] d, output logic oe);
        @(negedge clk);
        ce_n = 1'b0;
        oe_n = 1'b0;
        addr = a;
        repeat (R + 6) @(negedge clk);
        d  = dq_o;
        oe = dq_oe;
        oe_n = 1'b1;
        ce_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [15:0] d;
        logic        oe;
        chk("R1", "busy after reset", {15'd0, busy}, 16'd0);
        chk("R1", "dq_oe after reset", {15'd0, dq_oe}, 16'd0);
        rd(16'h0005, d, oe);
        chk("R1", "erased word", d, 16'hFFFF);
        chk("R3", "read drive enable", {15'd0, oe}, 16'd1);
    endtask

    task automatic t_program();
        logic [15:0] d;
        logic        oe;
        wr(16'h0000, 16'h0040);
        wr(16'h0012, 16'hA5F0);
        chk("R5", "busy during pulse", {15'd0, busy}, 16'd1);
        addr = 16'h0012;
        while (busy) @(negedge clk);
        chk("R4", "old word in commit cycle", dq_o, 16'hFFFF);
        @(negedge clk);
        chk("R4", "new word after commit", dq_o, 16'hA5F0);
        wr(16'h0000, 16'h0040);
        wr(16'h0012, 16'h0FFF);
        wait_idle();
        rd(16'h0012, d, oe);
        chk("R4", "AND of second program", d, 16'h05F0);
        rd(16'h0013, d, oe);
        chk("R4", "neighbour untouched", d, 16'hFFFF);
        rd(16'h0012, d, oe);
        chk("R3", "read of programmed word", d, 16'h05F0);
    endtask

    task automatic t_busy_len();
        int n = 0;
        wr(16'h0000, 16'h0040);
        fork
            wr(16'h0080, 16'h7777);
            begin
                @(negedge clk);
                while (!busy) @(negedge clk);
                while (busy) begin
                    n++;
                    @(negedge clk);
                end
            end
        join
        chk("R5", "busy length", 16'(n), 16'(P));
    endtask

    task automatic t_ignore_busy();
        logic [15:0] d;
        logic        oe;
        wr(16'h0000, 16'h0040);
        wr(16'h0030, 16'h00FF);
        wr(16'h0031, 16'h0040);
        chk("R5", "still busy after ignored write", {15'd0, busy}, 16'd1);
        wait_idle();
        wr(16'h0031, 16'h0000);
        wait_idle();
        rd(16'h0031, d, oe);
        chk("R5", "write during busy ignored", d, 16'hFFFF);
        rd(16'h0030, d, oe);
        chk("R4", "programmed word", d, 16'h00FF);
    endtask

    task automatic t_upper();
        logic [15:0] d;
        logic        oe;
        wr(16'h0000, 16'hAB40);
        wr(16'h0020, 16'h1234);
        wait_idle();
        rd(16'h0020, d, oe);
        chk("R9", "setup with upper byte set", d, 16'h1234);
    endtask

    task automatic t_verify();
        logic [15:0] d;
        logic        oe;
        wr(16'h0000, 16'h0040);
        wr(16'h0040, 16'h3C3C);
        wait_idle();
        wr(16'h0055, 16'h55C0);
        rd(16'h0099, d, oe);
        chk("R6", "verify word", d, 16'h3C3C);
        rd(16'h0123, d, oe);
        chk("R6", "verify address held", d, 16'h3C3C);
        wr(16'h0000, 16'h00FF);
        rd(16'h0099, d, oe);
        chk("R7", "back to read mode", d, 16'hFFFF);
    endtask

    task automatic t_oe_and_recovery();
        wait_idle();
        ce_n = 1'b0; oe_n = 1'b1;
        repeat (R + 6) @(negedge clk);
        chk("R2", "oe_n high", {15'd0, dq_oe}, 16'd0);
        ce_n = 1'b1; oe_n = 1'b0;
        repeat (6) @(negedge clk);
        chk("R2", "ce_n high", {15'd0, dq_oe}, 16'd0);
        ce_n = 1'b0;
        repeat (6) @(negedge clk);
        chk("R2", "both low", {15'd0, dq_oe}, 16'd1);
        dq_i = 16'h00FF;
        we_n = 1'b0;
        repeat (6) @(negedge clk);
        chk("R2", "we_n low", {15'd0, dq_oe}, 16'd0);
        we_n = 1'b1;
        repeat (6) @(negedge clk);
        chk("R8", "inside recovery", {15'd0, dq_oe}, 16'd0);
        repeat (R) @(negedge clk);
        chk("R8", "after recovery", {15'd0, dq_oe}, 16'd1);
        oe_n = 1'b1; ce_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_ce_gate();
        logic [15:0] d;
        logic        oe;
        wr(16'h0000, 16'h0040);
        wr(16'h0060, 16'h0000, 1'b0);
        chk("R10", "no busy without chip enable", {15'd0, busy}, 16'd0);
        wr(16'h0061, 16'h0F0F);
        wait_idle();
        rd(16'h0060, d, oe);
        chk("R10", "unselected write ignored", d, 16'hFFFF);
        rd(16'h0061, d, oe);
        chk("R10", "setup kept", d, 16'h0F0F);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        t_reset();
        t_program();
        t_busy_len();
        t_ignore_busy();
        t_upper();
        t_verify();
        t_oe_and_recovery();
        t_ce_gate();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R5 watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule